// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block holds the coherence state of every line of a small direct-mapped private cache attached to a shared, single-transaction snooping bus. Processor reads and writes arrive over a valid/ready request channel with a line address. The block completes hits locally. When the line is absent or its permission is too weak, it requests the bus. Once granted, it drives one address phase carrying a read, a read-for-ownership, an upgrade or a write-back. It samples the shared flag and fill data from the rest of the system one cycle later.

On the snoop side it watches the transactions of other caches. When one of them names a line it holds, it changes that line's state in the same edge. In the following cycle it drives a shared flag, a supply flag and, for a dirty line, the line data, which goes both to the requester and to memory. Each line stores a single data word in a register array.

The request channel accepts only while idle. `cpu_req_ready` is high in the idle state, and a request counts as taken on an edge where valid and ready are both high. The response is a single-cycle `cpu_rsp_valid` pulse with no back-pressure. The bus request stays asserted until granted, and the block assumes no snoop arrives while it owns the bus.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is high, and `bus_req`, `cpu_rsp_valid`, `snp_shared` and `snp_supply` are low. A snoop of any address then gets no shared or supply response.
- R2: A read to an absent line issues command 1 (read) for the request address. One cycle after the grant, the response returns `bus_rdata_in` and the line is installed. It becomes Shared if `bus_shared_in` was high in that cycle, and Exclusive otherwise.
- R3: A read that hits a valid line responds in the cycle after acceptance with the stored data and issues no bus request.
- R4: A write to an Exclusive line completes in the cycle after acceptance with no bus request, and the line becomes Modified.
- R5: A write to a Shared line issues command 3 (upgrade), and the line becomes Modified with the write data.
- R6: A write to an absent line issues command 2 (read-exclusive) and installs the line as Modified with the write data.
- R7: A snooped read (code 1) of a Modified line raises `snp_shared` and `snp_supply` with the line data, and the line becomes Shared.
- R8: A snooped read of an Exclusive or Shared line raises `snp_shared` without `snp_supply`, and the line becomes Shared.
- R9: A snooped read-exclusive (code 2) or upgrade (code 3) invalidates a held line. A Modified line answers a read-exclusive with `snp_supply` and its data first.
- R10: A miss whose index holds a different Modified line first issues command 4 (write-back), carrying the victim address and data, and only then the fill. A displaced Exclusive or Shared line is dropped with no bus traffic.
- R11: A snoop that hits the index of a request under lookup is applied first, and the request is then judged against the new state. For example, a write to an Exclusive line that is downgraded in that same cycle issues an upgrade.
- R12: `cpu_req_ready` stays low from acceptance until the response. Each accepted request gets exactly one response. `bus_req` is held until `bus_gnt`.
- R13: Snoop responses appear exactly one cycle after the snoop's valid cycle. A snoop of a line not held raises neither flag. Line states are encoded I=0, S=1, E=2, M=3 in two bits, and the index is the low address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Block can take a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | Access complete (one cycle) |
| cpu_rsp_rdata | output | DATA_W | Read data |
| bus_req | output | 1 | Request for the bus |
| bus_gnt | input | 1 | Grant; the grant cycle is the address phase |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-exclusive, 3 upgrade, 4 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_shared_in | input | 1 | Another cache holds the line (cycle after grant) |
| bus_rdata_in | input | DATA_W | Fill data (cycle after grant) |
| snp_valid | input | 1 | Foreign transaction address phase |
| snp_cmd | input | 3 | Foreign command, same codes as bus_cmd |
| snp_addr | input | ADDR_W | Foreign address |
| snp_shared | output | 1 | This cache held the line |
| snp_supply | output | 1 | This cache supplies dirty data |
| snp_data | output | DATA_W | Supplied data |

## Verification
The collision worth provoking is a snoop that hits the same index in the cycle the processor request is being looked up. Both of them would then update that line in one edge. The bench fills a line as Exclusive, then presents a processor write to it and a foreign read of it so that they land in the same cycle. It judges the outcome in two places: the snoop response must show a clean shared holder, and the write must then appear on the bus as an upgrade rather than finishing silently. Random runs mix snoops and accesses over a few aliasing addresses, so that the same overlap also occurs on reads and on lines with other states.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } line_st_e;

  typedef enum logic [2:0] {
    BC_NONE = 3'd0,
    BC_RD   = 3'd1,
    BC_RDX  = 3'd2,
    BC_UPGR = 3'd3,
    BC_WB   = 3'd4
  } bus_cmd_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store import mesi_pkg::*; #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  p_idx_i,
  output line_st_e          p_st_o,
  output logic [TAG_W-1:0]  p_tag_o,
  output logic [DATA_W-1:0] p_data_o,
  input  logic              p_we_i,
  input  line_st_e          p_nst_i,
  input  logic [TAG_W-1:0]  p_ntag_i,
  input  logic [DATA_W-1:0] p_ndata_i,
  input  logic [IDX_W-1:0]  s_idx_i,
  output line_st_e          s_st_o,
  output logic [TAG_W-1:0]  s_tag_o,
  output logic [DATA_W-1:0] s_data_o,
  input  logic              s_we_i,
  input  line_st_e          s_nst_i
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0][1:0]        st_all;
  logic [LINES-1:0][TAG_W-1:0]  tag_all;
  logic [LINES-1:0][DATA_W-1:0] data_all;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0]        st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic              s_sel, p_sel;
    assign s_sel = s_we_i && (s_idx_i == IDX_W'(g));
    assign p_sel = p_we_i && (p_idx_i == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q   <= LS_I;
        tag_q  <= '0;
        data_q <= '0;
      end else if (s_sel) begin
        st_q <= s_nst_i;
      end else if (p_sel) begin
        st_q   <= p_nst_i;
        tag_q  <= p_ntag_i;
        data_q <= p_ndata_i;
      end
    end
    assign st_all[g]   = st_q;
    assign tag_all[g]  = tag_q;
    assign data_all[g] = data_q;
  end

  assign p_st_o   = line_st_e'(st_all[p_idx_i]);
  assign p_tag_o  = tag_all[p_idx_i];
  assign p_data_o = data_all[p_idx_i];
  assign s_st_o   = line_st_e'(st_all[s_idx_i]);
  assign s_tag_o  = tag_all[s_idx_i];
  assign s_data_o = data_all[s_idx_i];

  AST_SNOOP_PROC_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (s_we_i && p_we_i) |-> (s_idx_i != p_idx_i)); // R11
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit import mesi_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid_i,
  input  logic [2:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic [IDX_W-1:0]  s_idx_o,
  input  line_st_e          s_st_i,
  input  logic [ADDR_W-IDX_W-1:0] s_tag_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_we_o,
  output line_st_e          s_nst_o,
  output logic              snp_hit_o,
  output logic              snp_shared_o,
  output logic              snp_supply_o,
  output logic [DATA_W-1:0] snp_data_o
);
  logic known_cmd, give;

  assign s_idx_o   = snp_addr_i[IDX_W-1:0];
  assign known_cmd = (snp_cmd_i == BC_RD) || (snp_cmd_i == BC_RDX) || (snp_cmd_i == BC_UPGR);
  assign snp_hit_o = snp_valid_i && known_cmd && (s_st_i != LS_I) &&
                     (s_tag_i == snp_addr_i[ADDR_W-1:IDX_W]);
  assign s_we_o    = snp_hit_o;
  assign s_nst_o   = (snp_cmd_i == BC_RD) ? LS_S : LS_I;
  assign give      = snp_hit_o && (s_st_i == LS_M) && (snp_cmd_i != BC_UPGR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_shared_o <= 1'b0;
      snp_supply_o <= 1'b0;
      snp_data_o   <= '0;
    end else begin
      snp_shared_o <= snp_hit_o;
      snp_supply_o <= give;
      snp_data_o   <= give ? s_data_i : '0;
    end
  end

  AST_SUPPLY_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply_o |-> ($past(s_st_i) == LS_M)); // R7
endmodule

// File: rtl/mesi_proc_fsm.sv
module mesi_proc_fsm import mesi_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid_i,
  output logic              cpu_req_ready_o,
  input  logic              cpu_req_write_i,
  input  logic [ADDR_W-1:0] cpu_req_addr_i,
  input  logic [DATA_W-1:0] cpu_req_wdata_i,
  output logic              cpu_rsp_valid_o,
  output logic [DATA_W-1:0] cpu_rsp_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_shared_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [IDX_W-1:0]  p_idx_o,
  input  line_st_e          p_st_i,
  input  logic [ADDR_W-IDX_W-1:0] p_tag_i,
  input  logic [DATA_W-1:0] p_data_i,
  output logic              p_we_o,
  output line_st_e          p_nst_o,
  output logic [ADDR_W-IDX_W-1:0] p_ntag_o,
  output logic [DATA_W-1:0] p_ndata_o,
  input  logic              snp_hit_i,
  input  logic [IDX_W-1:0]  snp_idx_i
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {P_IDLE, P_LOOK, P_WAIT, P_RESP} pst_e;

  pst_e              state_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  bus_cmd_e          cmd_q, need;
  logic [TAG_W-1:0]  tg;
  logic              hit, collide;

  assign p_idx_o = addr_q[IDX_W-1:0];
  assign tg      = addr_q[ADDR_W-1:IDX_W];
  assign hit     = (p_st_i != LS_I) && (p_tag_i == tg);
  assign collide = snp_hit_i && (snp_idx_i == p_idx_o);

  always_comb begin
    if (p_st_i == LS_M && p_tag_i != tg) need = BC_WB;
    else if (hit)                        need = (wr_q && p_st_i == LS_S) ? BC_UPGR : BC_NONE;
    else                                 need = wr_q ? BC_RDX : BC_RD;
  end

  assign cpu_req_ready_o = (state_q == P_IDLE);
  assign bus_req_o       = (state_q == P_WAIT);
  assign bus_cmd_o       = bus_req_o ? need : BC_NONE;
  assign bus_addr_o      = !bus_req_o ? '0 : (need == BC_WB) ? {p_tag_i, p_idx_o} : addr_q;
  assign bus_wdata_o     = (bus_req_o && need == BC_WB) ? p_data_i : '0;

  always_comb begin
    cpu_rsp_valid_o = 1'b0;
    cpu_rsp_rdata_o = '0;
    p_we_o    = 1'b0;
    p_nst_o   = LS_M;
    p_ntag_o  = tg;
    p_ndata_o = wdata_q;
    if (state_q == P_LOOK && !collide && need == BC_NONE) begin
      cpu_rsp_valid_o = 1'b1;
      cpu_rsp_rdata_o = wr_q ? '0 : p_data_i;
      p_we_o          = wr_q;
    end else if (state_q == P_RESP) begin
      p_we_o = 1'b1;
      if (cmd_q == BC_WB) begin
        p_nst_o   = LS_I;
        p_ntag_o  = p_tag_i;
        p_ndata_o = p_data_i;
      end else begin
        cpu_rsp_valid_o = 1'b1;
        if (cmd_q == BC_RD) begin
          p_nst_o         = bus_shared_i ? LS_S : LS_E;
          p_ndata_o       = bus_rdata_i;
          cpu_rsp_rdata_o = bus_rdata_i;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= P_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      cmd_q   <= BC_NONE;
    end else begin
      case (state_q)
        P_IDLE: if (cpu_req_valid_i) begin
          wr_q    <= cpu_req_write_i;
          addr_q  <= cpu_req_addr_i;
          wdata_q <= cpu_req_wdata_i;
          state_q <= P_LOOK;
        end
        P_LOOK: if (!collide) state_q <= (need == BC_NONE) ? P_IDLE : P_WAIT;
        P_WAIT: if (bus_gnt_i) begin
          cmd_q   <= need;
          state_q <= P_RESP;
        end
        P_RESP: state_q <= (cmd_q == BC_WB) ? P_WAIT : P_IDLE;
        default: state_q <= P_IDLE;
      endcase
    end
  end

  AST_BUS_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_gnt_i) |=> bus_req_o); // R12
  AST_RSP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid_o |-> !cpu_req_ready_o); // R12
  AST_EXCL_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == P_LOOK && !collide && wr_q && hit && p_st_i == LS_E) |=> (p_st_i == LS_M)); // R4
  AST_WB_LEAVES_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == P_RESP && cmd_q == BC_WB) |=> (p_st_i == LS_I)); // R10
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl import mesi_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_shared_in,
  input  logic [DATA_W-1:0] bus_rdata_in,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  p_idx, s_idx;
  line_st_e          p_st, s_st, p_nst, s_nst;
  logic [TAG_W-1:0]  p_tag, s_tag, p_ntag;
  logic [DATA_W-1:0] p_data, s_data, p_ndata;
  logic              p_we, s_we, snp_hit;

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk, .rst_n,
    .p_idx_i(p_idx), .p_st_o(p_st), .p_tag_o(p_tag), .p_data_o(p_data),
    .p_we_i(p_we), .p_nst_i(p_nst), .p_ntag_i(p_ntag), .p_ndata_i(p_ndata),
    .s_idx_i(s_idx), .s_st_o(s_st), .s_tag_o(s_tag), .s_data_o(s_data),
    .s_we_i(s_we), .s_nst_i(s_nst)
  );

  mesi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
    .clk, .rst_n,
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .s_idx_o(s_idx), .s_st_i(s_st), .s_tag_i(s_tag), .s_data_i(s_data),
    .s_we_o(s_we), .s_nst_o(s_nst), .snp_hit_o(snp_hit),
    .snp_shared_o(snp_shared), .snp_supply_o(snp_supply), .snp_data_o(snp_data)
  );

  mesi_proc_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk, .rst_n,
    .cpu_req_valid_i(cpu_req_valid), .cpu_req_ready_o(cpu_req_ready),
    .cpu_req_write_i(cpu_req_write), .cpu_req_addr_i(cpu_req_addr),
    .cpu_req_wdata_i(cpu_req_wdata), .cpu_rsp_valid_o(cpu_rsp_valid),
    .cpu_rsp_rdata_o(cpu_rsp_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_shared_i(bus_shared_in), .bus_rdata_i(bus_rdata_in),
    .p_idx_o(p_idx), .p_st_i(p_st), .p_tag_i(p_tag), .p_data_i(p_data),
    .p_we_o(p_we), .p_nst_o(p_nst), .p_ntag_o(p_ntag), .p_ndata_o(p_ndata),
    .snp_hit_i(snp_hit), .snp_idx_i(s_idx)
  );
endmodule

// File: tb/tb_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_snoop_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req_valid = 0, cpu_req_write = 0;
  logic [7:0] cpu_req_addr = 0;
  logic [15:0] cpu_req_wdata = 0;
  logic cpu_req_ready, cpu_rsp_valid, bus_req, snp_shared, snp_supply;
  logic [15:0] cpu_rsp_rdata, bus_wdata, snp_data;
  logic bus_gnt = 0, bus_shared_in = 0, snp_valid = 0;
  logic [2:0] bus_cmd, snp_cmd = 0;
  logic [7:0] bus_addr, snp_addr = 0;
  logic [15:0] bus_rdata_in = 0;

  int checks = 0, fails = 0;
  int ref_st [4];
  logic [5:0]  ref_tag [4];
  logic [15:0] ref_data [4];
  logic [15:0] mem [256];
  int force_sh = -1;
  bit finished = 0;

  mesi_snoop_ctrl dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_cmd(input bit wr, input logic [7:0] a);
    int i = int'(a[1:0]);
    bit h = (ref_st[i] != 0) && (ref_tag[i] == a[7:2]);
    if (ref_st[i] == 3 && !h) return 4;
    if (h) return (wr && ref_st[i] == 1) ? 3 : 0;
    return wr ? 2 : 1;
  endfunction

  task automatic cpu_issue(input bit wr, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    chk(cpu_req_ready == 1'b1, "R12 ready when idle", cpu_req_ready, 1);
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
    @(posedge clk);
  endtask

  task automatic cpu_finish(input bit wr, input logic [7:0] a, input logic [15:0] d);
    int i = int'(a[1:0]);
    bit done = 0, pend = 0, sh = 0;
    int pc = 0, e;
    for (int n = 0; n < 40 && !done; n++) begin
      @(negedge clk);
      cpu_req_valid = 0; bus_gnt = 0; bus_shared_in = 0; bus_rdata_in = 0;
      if (pend) begin
        sh = (force_sh < 0) ? bit'($urandom % 2) : bit'(force_sh);
        bus_shared_in = sh; bus_rdata_in = mem[a];
      end
      #1;
      if (pend) begin
        pend = 0;
        if (pc == 4) begin
          chk(cpu_rsp_valid == 0, "R10 no response after write-back", cpu_rsp_valid, 0);
          mem[{ref_tag[i], a[1:0]}] = ref_data[i];
          ref_st[i] = 0;
        end else begin
          chk(cpu_rsp_valid == 1, "R12 response after fill", cpu_rsp_valid, 1);
          if (pc == 1) begin
            chk(cpu_rsp_rdata == mem[a], "R2 fill data", cpu_rsp_rdata, mem[a]);
            ref_st[i] = sh ? 1 : 2; ref_data[i] = mem[a];
          end else begin
            ref_st[i] = 3; ref_data[i] = d;
          end
          ref_tag[i] = a[7:2];
          done = 1;
        end
      end else if (cpu_rsp_valid) begin
        e = exp_cmd(wr, a);
        chk(e == 0, "R3 local completion only on hit", 0, e);
        if (!wr) chk(cpu_rsp_rdata == ref_data[i], "R3 hit data", cpu_rsp_rdata, ref_data[i]);
        else begin
          ref_st[i] = 3; ref_data[i] = d;
        end
        done = 1;
      end else if (bus_req) begin
        e = exp_cmd(wr, a);
        chk(int'(bus_cmd) == e, (e == 4) ? "R10 write-back cmd" : (e == 3) ? "R5 upgrade cmd" :
            (e == 2) ? "R6 read-exclusive cmd" : "R2 read cmd", bus_cmd, e);
        if (e == 4) begin
          chk(bus_addr == {ref_tag[i], a[1:0]}, "R10 victim address", bus_addr, {ref_tag[i], a[1:0]});
          chk(bus_wdata == ref_data[i], "R10 victim data", bus_wdata, ref_data[i]);
        end else chk(bus_addr == a, "R2 request address", bus_addr, a);
        pc = e; pend = 1; bus_gnt = 1;
      end else if (n > 0) begin
        chk(cpu_req_ready == 0, "R12 ready low while busy", cpu_req_ready, 0);
      end
    end
    if (!done) chk(0, "R12 request never completed", 0, 1);
    @(negedge clk);
    bus_gnt = 0; bus_shared_in = 0;
  endtask

  task automatic cpu_op(input bit wr, input logic [7:0] a, input logic [15:0] d);
    cpu_issue(wr, a, d);
    cpu_finish(wr, a, d);
  endtask

  task automatic snp_expect(input logic [2:0] c, input logic [7:0] a,
                            output bit h, output bit sup, output logic [15:0] dat);
    int i = int'(a[1:0]);
    h   = (ref_st[i] != 0) && (ref_tag[i] == a[7:2]) && c >= 1 && c <= 3;
    sup = h && ref_st[i] == 3 && c != 3;
    dat = ref_data[i];
  endtask

  task automatic snp_judge(input logic [2:0] c, input logic [7:0] a,
                           input bit h, input bit sup, input logic [15:0] dat);
    int i = int'(a[1:0]);
    chk(snp_shared == h, h ? "R8 shared on held line" : "R13 no shared on miss", snp_shared, h);
    chk(snp_supply == sup, (c == 2) ? "R9 supply on read-exclusive" : "R7 supply on dirty read",
        snp_supply, sup);
    if (sup) chk(snp_data == dat, "R7 supplied data", snp_data, dat);
    if (h) begin
      if (c == 1) begin
        if (sup) mem[a] = dat;
        ref_st[i] = 1;
      end else ref_st[i] = 0;
    end
  endtask

  task automatic snoop(input logic [2:0] c, input logic [7:0] a);
    bit h, sup; logic [15:0] dat;
    snp_expect(c, a, h, sup, dat);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 0;
    #1;
    snp_judge(c, a, h, sup, dat);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit h, sup; logic [15:0] dat;
    void'($urandom(32'd4242));
    for (int k = 0; k < 256; k++) mem[k] = 16'hA000 + 16'(k * 37);
    for (int k = 0; k < 4; k++) begin ref_st[k] = 0; ref_tag[k] = 0; ref_data[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(cpu_req_ready == 1, "R1 ready after reset", cpu_req_ready, 1);
    chk(bus_req == 0, "R1 no bus request after reset", bus_req, 0);
    chk(cpu_rsp_valid == 0 && snp_shared == 0 && snp_supply == 0, "R1 outputs quiet", 0, 0);
    snoop(3'd1, 8'h00);  // R1: every line invalid

    force_sh = 0;
    cpu_op(0, 8'h04, 0);                // R2 install E
    cpu_op(0, 8'h04, 0);                // R3 hit
    cpu_op(1, 8'h04, 16'h1111);         // R4 silent
    snoop(3'd1, 8'h04);                 // R7 supply, S
    cpu_op(1, 8'h04, 16'h2222);         // R5 upgrade
    snoop(3'd2, 8'h04);                 // R9 supply + invalidate
    cpu_op(1, 8'h08, 16'h3333);         // R6 read-exclusive
    force_sh = 1;
    cpu_op(0, 8'h0C, 0);                // R10 write-back then R2 fill as S
    snoop(3'd1, 8'h0C);                 // R8 shared only
    cpu_op(0, 8'h10, 0);                // R10 silent drop of S
    snoop(3'd3, 8'h10);                 // R9 upgrade invalidates
    cpu_op(0, 8'h10, 0);                // R2 refetch

    // R11: snoop and write lookup on the same line in the same cycle
    force_sh = 0;
    cpu_op(0, 8'h05, 0);
    snp_expect(3'd1, 8'h05, h, sup, dat);
    cpu_issue(1, 8'h05, 16'h5555);
    @(negedge clk);
    cpu_req_valid = 0; snp_valid = 1; snp_cmd = 3'd1; snp_addr = 8'h05;
    @(negedge clk);
    snp_valid = 0; #1;
    snp_judge(3'd1, 8'h05, h, sup, dat);
    chk(cpu_rsp_valid == 0, "R11 write not silent after downgrade", cpu_rsp_valid, 0);
    cpu_finish(1, 8'h05, 16'h5555);     // expects upgrade (R11)

    force_sh = -1;
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a = 8'($urandom % 16);
      int sel = int'($urandom % 10);
      int i = int'(a[1:0]);
      if (sel < 6) cpu_op(bit'($urandom % 2), a, 16'($urandom));
      else begin
        logic [2:0] c = 3'(1 + $urandom % 3);
        if (c == 3 && (ref_st[i] >= 2) && ref_tag[i] == a[7:2]) c = 3'd2;
        snoop(c, a);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule